// File: doc/BRIEF.md
# Flag-Producing 32-bit ALU with Iterative Multiply

This block is the execute-stage arithmetic unit of a small RISC core with 16-bit instructions. Each request carries two register operands, a 4-bit operation code and the current condition flags. The block returns a registered result, a write-enable for the destination register, the new flags and the number of internal cycles the operation costs. Fifteen of the sixteen operations finish one cycle after they are accepted. The multiply works through the multiplier one byte per cycle and stops as soon as the remaining bytes are only sign extension.

Requests use a valid/ready handshake. A request is accepted on a rising clock edge where `reqValid` and `reqReady` are both high. `rspValid` is a one-cycle pulse, and the response outputs hold their values until the next response. Flags are packed as {N, Z, C, V} in bits [3:0], so N is bit 3, Z is bit 2, C is bit 1 and V is bit 0.

Top module: `flag_alu`

## Requirements
- R1: Operation codes 0 to 15 select, in this order: AND, EOR, LSL, LSR, ASR, ADC, SBC, ROR, TST, NEG, CMP, CMN, ORR, MUL, BIC, MVN. AND and TST give a&b, EOR gives a^b, ORR gives a|b, BIC gives a&~b and MVN gives ~b. These logical operations leave C and V at their input values.
- R2: `writeEn` is 0 for TST (8), CMP (10) and CMN (11) and 1 for every other operation. `result` still carries the computed value for these three.
- R3: LSL and LSR shift by b[7:0]. For amounts 1 to 31, C is the last bit shifted out. For an amount of exactly 32 the result is zero and C is a[0] for LSL or a[31] for LSR. Above 32 both the result and C are zero.
- R4: ASR by b[7:0] in the range 1 to 31 shifts in copies of the sign bit, and C is the last bit shifted out. For 32 or more, every result bit equals a[31] and C equals a[31].
- R5: ROR rotates right by b[4:0] whenever b[7:0] is non-zero. C becomes bit 31 of the result, and a non-zero multiple of 32 leaves the value unchanged.
- R6: For all four shifts, an amount byte b[7:0] of zero passes a through unchanged and keeps C, even when the upper bits of b are set.
- R7: ADC gives a+b+C and CMN gives a+b. C is the carry out of bit 31. V is set when the operands have equal signs and the sum's sign differs from them.
- R8: SBC gives a-b-(1-C), CMP gives a-b and NEG gives 0-b. C is 1 when no borrow occurs, and V is set on signed overflow of the subtraction.
- R9: For every operation, N is bit 31 of `result` and Z is 1 exactly when `result` is zero.
- R10: MUL gives the low 32 bits of a*b and leaves C and V at their input values.
- R11: `costOut` is 0 for non-shift single-cycle operations and 1 for the four shifts. For MUL it is m, the smallest k in 1 to 3 such that b fits in a signed 8k-bit value, otherwise 4.
- R12: After reset, `reqReady` is 1 and `rspValid` is 0. A non-MUL request gives `rspValid` one cycle after acceptance. A MUL request gives it m+1 cycles after acceptance, and `reqReady` stays low until the response cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| opCode | input | 4 | Operation select (R1 order) |
| opA | input | 32 | First operand (destination register value) |
| opB | input | 32 | Second operand, shift amount or multiplier |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| rspValid | output | 1 | One-cycle response strobe |
| result | output | 32 | Operation result |
| writeEn | output | 1 | Destination register should be written |
| flagsOut | output | 4 | Updated flags {N,Z,C,V} |
| costOut | output | 3 | Internal cycles the operation costs |

## Verification
Every operation code is swept against eight first operands and twelve second operands under four incoming flag patterns, and each response is compared with a reference computed arithmetically. The second operands include shift amounts of 0, 1, 5, 31, 32 and 33, plus values whose low byte is zero but whose upper bits are set. These separate the exact-32 carry rule from the above-32 rule and show that only the amount byte matters. Sign-boundary values such as 0x7FFFFFFF, 0x80000000 and -1 expose carry and overflow errors in the adder. Multipliers whose significant width is one, two, three and four bytes pin down both the early-stop latency and the signed treatment of the final byte.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0, OP_EOR, OP_LSL, OP_LSR, OP_ASR, OP_ADC, OP_SBC, OP_ROR,
    OP_TST, OP_NEG, OP_CMP, OP_CMN, OP_ORR, OP_MUL, OP_BIC, OP_MVN
  } aluOp_e;

  typedef enum logic [1:0] {SH_LSL, SH_LSR, SH_ASR, SH_ROR} shiftKind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } aluFlags_t;

  typedef struct packed {
    logic capture;
    logic mulLoad;
    logic mulStep;
    logic mulLast;
  } ctrlStrobe_t;

endpackage

// File: rtl/alu_shifter.sv
module alu_shifter
  import flag_alu_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 8
) (
  input  shiftKind_e       kind,
  input  logic [W-1:0]     src,
  input  logic [AW-1:0]    amt,
  input  logic             cIn,
  output logic [W-1:0]     res,
  output logic             cOut
);
  localparam int RW = $clog2(W);
  localparam logic [AW-1:0] FULL = AW'(W);

  logic [W:0]    wide;
  logic [RW-1:0] rot;

  always_comb begin
    res  = src;
    cOut = cIn;
    wide = '0;
    rot  = amt[RW-1:0];
    if (amt != '0) begin
      case (kind)
        SH_LSL: begin
          if (amt < FULL) begin
            wide = {1'b0, src} << amt;
            res  = wide[W-1:0];
            cOut = wide[W];
          end else begin
            res  = '0;
            cOut = (amt == FULL) ? src[0] : 1'b0;
          end
        end
        SH_LSR: begin
          if (amt < FULL) begin
            wide = {src, 1'b0} >> amt;
            res  = wide[W:1];
            cOut = wide[0];
          end else begin
            res  = '0;
            cOut = (amt == FULL) ? src[W-1] : 1'b0;
          end
        end
        SH_ASR: begin
          if (amt < FULL) begin
            wide = $signed({src, 1'b0}) >>> amt;
            res  = wide[W:1];
            cOut = wide[0];
          end else begin
            res  = {W{src[W-1]}};
            cOut = src[W-1];
          end
        end
        default: begin
          res  = (src >> rot) | (src << (W - rot));
          cOut = res[W-1];
        end
      endcase
    end
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import flag_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AW    = 8,
  parameter int SLICE = 8,
  parameter int NB    = W / SLICE,
  parameter int CW    = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  ctrlStrobe_t   strobe,
  input  aluOp_e        opCode,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  aluFlags_t     flagsIn,
  output logic [CW-1:0] mulBytes,
  output logic [W-1:0]  resQ,
  output logic          weQ,
  output aluFlags_t     flagsQ,
  output logic [CW-1:0] costQ
);
  localparam logic [AW-1:0] FULL = AW'(W);

  shiftKind_e    shKind;
  logic [W-1:0]  shRes;
  logic          shC;

  logic [W-1:0]  addX, addY;
  logic          addCin;
  logic [W:0]    sum;
  logic          arithV;

  logic [W-1:0]  nextRes;
  aluFlags_t     nextFlags;
  logic          nextWe;
  logic [CW-1:0] nextCost;

  logic [W-1:0]  mcand, mplier, acc, partial, mulSum, signTop;
  aluFlags_t     keepFlags;

  always_comb begin
    case (opCode)
      OP_LSL:  shKind = SH_LSL;
      OP_LSR:  shKind = SH_LSR;
      OP_ASR:  shKind = SH_ASR;
      default: shKind = SH_ROR;
    endcase
  end

  alu_shifter #(.W(W), .AW(AW)) uShift (
    .kind(shKind), .src(opA), .amt(opB[AW-1:0]), .cIn(flagsIn.c),
    .res(shRes), .cOut(shC)
  );

  // One adder serves every add and subtract form; subtraction feeds ~b.
  always_comb begin
    addX   = opA;
    addY   = opB;
    addCin = 1'b0;
    case (opCode)
      OP_ADC: addCin = flagsIn.c;
      OP_SBC: begin addY = ~opB; addCin = flagsIn.c; end
      OP_NEG: begin addX = '0; addY = ~opB; addCin = 1'b1; end
      OP_CMP: begin addY = ~opB; addCin = 1'b1; end
      default: ;
    endcase
  end

  assign sum    = {1'b0, addX} + {1'b0, addY} + {{W{1'b0}}, addCin};
  assign arithV = (addX[W-1] == addY[W-1]) && (sum[W-1] != addX[W-1]);

  always_comb begin
    nextRes   = '0;
    nextFlags = flagsIn;
    nextWe    = 1'b1;
    nextCost  = '0;
    case (opCode)
      OP_AND, OP_TST: nextRes = opA & opB;
      OP_EOR:         nextRes = opA ^ opB;
      OP_ORR:         nextRes = opA | opB;
      OP_BIC:         nextRes = opA & ~opB;
      OP_MVN:         nextRes = ~opB;
      OP_LSL, OP_LSR, OP_ASR, OP_ROR: begin
        nextRes     = shRes;
        nextFlags.c = shC;
        nextCost    = CW'(1);
      end
      OP_ADC, OP_SBC, OP_NEG, OP_CMP, OP_CMN: begin
        nextRes     = sum[W-1:0];
        nextFlags.c = sum[W];
        nextFlags.v = arithV;
      end
      default: nextRes = '0;
    endcase
    if (opCode == OP_TST || opCode == OP_CMP || opCode == OP_CMN) nextWe = 1'b0;
    nextFlags.n = nextRes[W-1];
    nextFlags.z = (nextRes == '0);
  end

  // Significant multiplier bytes: smallest k whose upper bits are pure sign.
  always_comb begin
    mulBytes = CW'(NB);
    signTop  = '0;
    for (int k = NB - 1; k >= 1; k--) begin
      signTop = $signed(opB) >>> (SLICE * k - 1);
      if (signTop == '0 || signTop == '1) mulBytes = CW'(k);
    end
  end

  // Unsigned bytes, except the last which is taken as signed.
  always_comb begin
    partial = mcand * {{(W-SLICE){1'b0}}, mplier[SLICE-1:0]};
    if (strobe.mulLast && mplier[SLICE-1]) partial = partial - (mcand << SLICE);
    mulSum = acc + partial;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resQ      <= '0;
      weQ       <= 1'b0;
      flagsQ    <= '0;
      costQ     <= '0;
      mcand     <= '0;
      mplier    <= '0;
      acc       <= '0;
      keepFlags <= '0;
    end else begin
      if (strobe.capture) begin
        resQ   <= nextRes;
        weQ    <= nextWe;
        flagsQ <= nextFlags;
        costQ  <= nextCost;
      end
      if (strobe.mulLoad) begin
        mcand     <= opA;
        mplier    <= opB;
        acc       <= '0;
        keepFlags <= flagsIn;
        costQ     <= mulBytes;
      end
      if (strobe.mulStep) begin
        acc    <= mulSum;
        mcand  <= mcand << SLICE;
        mplier <= mplier >> SLICE;
        if (strobe.mulLast) begin
          resQ   <= mulSum;
          weQ    <= 1'b1;
          flagsQ <= '{n: mulSum[W-1], z: (mulSum == '0), c: keepFlags.c, v: keepFlags.v};
        end
      end
    end
  end

  // R2
  cmp_nowrite_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && (opCode == OP_TST || opCode == OP_CMP || opCode == OP_CMN)) |=> !weQ);

  // R3
  lsr_far_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && opCode == OP_LSR && opB[AW-1:0] >= FULL) |=> resQ == '0);

  // R11
  mul_cost_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mulLoad |=> (costQ >= CW'(1) && costQ <= CW'(NB)));

  // R10
  mul_flag_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mulLast |=> (flagsQ.c == $past(keepFlags.c) && flagsQ.v == $past(keepFlags.v)));

endmodule

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import flag_alu_pkg::*;
#(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  aluOp_e        opCode,
  input  logic [CW-1:0] mulBytes,
  output logic          reqReady,
  output logic          rspValid,
  output ctrlStrobe_t   strobe
);
  typedef enum logic {ST_IDLE, ST_MUL} ctrlState_e;

  ctrlState_e    state;
  logic [CW-1:0] remain;
  logic          accept;

  assign reqReady       = (state == ST_IDLE);
  assign accept         = reqValid && reqReady;
  assign strobe.capture = accept && (opCode != OP_MUL);
  assign strobe.mulLoad = accept && (opCode == OP_MUL);
  assign strobe.mulStep = (state == ST_MUL);
  assign strobe.mulLast = strobe.mulStep && (remain == CW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      remain   <= '0;
      rspValid <= 1'b0;
    end else begin
      rspValid <= strobe.capture || strobe.mulLast;
      if (strobe.mulLoad) begin
        state  <= ST_MUL;
        remain <= mulBytes;
      end
      if (strobe.mulStep) begin
        remain <= remain - CW'(1);
        if (strobe.mulLast) state <= ST_IDLE;
      end
    end
  end

  // R12
  single_cycle_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && opCode != OP_MUL) |=> rspValid);

  // R12
  mul_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mulLoad |=> (!reqReady && !rspValid));

endmodule

// File: rtl/flag_alu.sv
module flag_alu
  import flag_alu_pkg::*;
#(
  parameter int W     = 32,
  parameter int AW    = 8,
  parameter int SLICE = 8,
  parameter int NB    = W / SLICE,
  parameter int CW    = $clog2(NB + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  output logic          reqReady,
  input  logic [3:0]    opCode,
  input  logic [W-1:0]  opA,
  input  logic [W-1:0]  opB,
  input  logic [3:0]    flagsIn,
  output logic          rspValid,
  output logic [W-1:0]  result,
  output logic          writeEn,
  output logic [3:0]    flagsOut,
  output logic [CW-1:0] costOut
);
  aluOp_e        opSel;
  aluFlags_t     fIn, fOut;
  ctrlStrobe_t   strobe;
  logic [CW-1:0] mulBytes;

  assign opSel    = aluOp_e'(opCode);
  assign fIn      = flagsIn;
  assign flagsOut = fOut;

  alu_ctrl #(.CW(CW)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opCode(opSel),
    .mulBytes(mulBytes), .reqReady(reqReady), .rspValid(rspValid), .strobe(strobe)
  );

  alu_datapath #(.W(W), .AW(AW), .SLICE(SLICE), .NB(NB), .CW(CW)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .opCode(opSel), .opA(opA), .opB(opB),
    .flagsIn(fIn), .mulBytes(mulBytes), .resQ(result), .weQ(writeEn),
    .flagsQ(fOut), .costQ(costOut)
  );

  // R9
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> (flagsOut[2] == (result == '0) && flagsOut[3] == result[W-1]));

endmodule

// File: tb/tb_flag_alu.sv
`timescale 1ns/1ps
module tb_flag_alu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [3:0]  opCode = '0;
  logic [31:0] opA = '0, opB = '0;
  logic [3:0]  flagsIn = '0;
  logic        rspValid;
  logic [31:0] result;
  logic        writeEn;
  logic [3:0]  flagsOut;
  logic [2:0]  costOut;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  flag_alu dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .opCode(opCode), .opA(opA), .opB(opB), .flagsIn(flagsIn),
    .rspValid(rspValid), .result(result), .writeEn(writeEn),
    .flagsOut(flagsOut), .costOut(costOut)
  );

  logic [31:0] aVals [8] = '{32'h0, 32'h1, 32'h139B4FE1, 32'h7FFFFFFF,
                             32'h80000000, 32'hFFFFFFFF, 32'hFAFFFFF0, 32'h00005A5A};
  logic [31:0] bVals [12] = '{32'd0, 32'd1, 32'd5, 32'd31, 32'd32, 32'd33,
                              32'hFFFFFC21, 32'h000003E1, 32'h80000000,
                              32'h7FFFFFFF, 32'h00012345, 32'hFFFFFF80};

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic string opTag(input int op, input logic [7:0] amt);
    case (op)
      2, 3:    return (amt == 0) ? "R6" : "R3";
      4:       return (amt == 0) ? "R6" : "R4";
      7:       return (amt == 0) ? "R6" : "R5";
      5, 11:   return "R7";
      6, 9, 10: return "R8";
      13:      return "R10";
      default: return "R1";
    endcase
  endfunction

  function automatic void refModel(input int op, input logic [31:0] a, input logic [31:0] b,
                                   input logic [3:0] f, output logic [31:0] r,
                                   output logic [3:0] fo, output logic we, output int cost);
    logic c, v;
    int amt;
    logic [32:0] s;
    logic [63:0] p;
    longint sb;
    c = f[1]; v = f[0]; amt = int'(b[7:0]);
    we = !(op == 8 || op == 10 || op == 11);
    cost = 0; r = a;
    case (op)
      0, 8: r = a & b;
      1:    r = a ^ b;
      12:   r = a | b;
      14:   r = a & ~b;
      15:   r = ~b;
      2: begin
        cost = 1;
        if (amt == 0) r = a;
        else if (amt < 32) begin r = a << amt; c = a[32-amt]; end
        else if (amt == 32) begin r = 0; c = a[0]; end
        else begin r = 0; c = 1'b0; end
      end
      3: begin
        cost = 1;
        if (amt == 0) r = a;
        else if (amt < 32) begin r = a >> amt; c = a[amt-1]; end
        else if (amt == 32) begin r = 0; c = a[31]; end
        else begin r = 0; c = 1'b0; end
      end
      4: begin
        cost = 1;
        if (amt == 0) r = a;
        else if (amt < 32) begin r = 32'($signed(a) >>> amt); c = a[amt-1]; end
        else begin r = {32{a[31]}}; c = a[31]; end
      end
      7: begin
        cost = 1;
        if (amt != 0) begin
          int s5;
          s5 = amt % 32;
          r = (a >> s5) | (a << (32 - s5));
          c = r[31];
        end
      end
      5, 11: begin
        s = {1'b0, a} + {1'b0, b} + ((op == 5) ? 33'(c) : 33'd0);
        r = s[31:0]; c = s[32];
        v = (a[31] == b[31]) && (r[31] != a[31]);
      end
      6: begin
        s = {1'b0, a} + {1'b0, ~b} + 33'(c);
        r = s[31:0]; c = s[32];
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      10: begin
        r = a - b; c = (a >= b);
        v = (a[31] != b[31]) && (r[31] != a[31]);
      end
      9: begin
        r = 32'd0 - b; c = (b == 0); v = (b == 32'h80000000);
      end
      default: begin
        p = {32'b0, a} * {32'b0, b};
        r = p[31:0];
        sb = $signed(b);
        if (sb >= -128 && sb <= 127) cost = 1;
        else if (sb >= -32768 && sb <= 32767) cost = 2;
        else if (sb >= -8388608 && sb <= 8388607) cost = 3;
        else cost = 4;
      end
    endcase
    fo = {r[31], (r == 0), c, v};
  endfunction

  task automatic runOne(input int op, input logic [31:0] a, input logic [31:0] b,
                        input logic [3:0] f);
    logic [31:0] er;
    logic [3:0]  ef;
    logic        ew;
    int          ec, lat, expLat;
    bit          readyLow;
    string       tg;
    refModel(op, a, b, f, er, ef, ew, ec);
    tg = opTag(op, b[7:0]);
    @(negedge clk);
    opCode = 4'(op); opA = a; opB = b; flagsIn = f; reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    lat = 1; readyLow = 1'b1;
    while (!rspValid && lat < 12) begin
      if (reqReady) readyLow = 1'b0;
      @(negedge clk);
      lat++;
    end
    expLat = (op == 13) ? ec + 1 : 1;
    check(result == er, tg, "result", result, er);
    check(flagsOut == ef, {"R9/", tg}, "flags", 32'(flagsOut), 32'(ef));
    check(writeEn == ew, "R2", "writeEn", 32'(writeEn), 32'(ew));
    check(int'(costOut) == ec, "R11", "cost", 32'(costOut), 32'(ec));
    check(lat == expLat, "R12", "latency", 32'(lat), 32'(expLat));
    if (op == 13) check(readyLow, "R12", "ready low while multiplying", 32'(readyLow), 32'd1);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R12", "reset ready", 32'(reqReady), 32'd1);
    check(rspValid == 1'b0, "R12", "reset rspValid", 32'(rspValid), 32'd0);
    for (int op = 0; op < 16; op++)
      for (int ia = 0; ia < 8; ia++)
        for (int ib = 0; ib < 12; ib++)
          for (int fi = 0; fi < 4; fi++)
            runOne(op, aVals[ia], bVals[ib], {fi[0], ~fi[1], fi[0], fi[1]});
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule